// File: doc/BRIEF.md
# Digit-Serial Montgomery Modular Multiplier

This block computes the Montgomery product `A·B·2^(-N) mod M` for an odd N-bit modulus M. Software or a surrounding exponentiation engine supplies A, B, M and the constant `mp = -M^(-1) mod 2^K`, then pulses `start`. The multiplier operand A is consumed one K-bit digit per cycle, lowest digit first. After each digit the accumulator is divided by 2^K. The accumulator is held as a pair of sum and carry vectors, so no iteration waits on a long carry chain.

The quotient digit that makes the low K bits of the accumulator vanish is registered one cycle ahead of its use. For that reason a single preparation cycle comes before the N/K digit cycles. When the digits are used up, a carry-skip adder collapses the redundant accumulator into binary. One conditional subtraction of M then gives a value in `[0, M)`. Computing `mp` and converting values into or out of the Montgomery domain are left to the caller.

Top module: `mm_montmul`

## Requirements
- R1: With M odd, B < M, any N-bit A and `mp_in` equal to `-M^(-1) mod 2^K`, `result` equals `A·B·2^(-N) mod M` when `done` is high.
- R2: `result` always lies in `[0, M)`. This holds for the largest modulus `2^N - 1`, for operands `A = B = M - 1`, and for `M = 1`, where the result is 0.
- R3: If A is 0, or B is 0, the result is 0.
- R4: `done` goes high right after the (N/K + 3)-th rising edge that follows the edge which accepts `start`.
- R5: `done` stays high for exactly one cycle per accepted operation.
- R6: `result` keeps its value from the moment `done` rises until the next accepted operation completes.
- R7: A `start` that arrives while `busy` is high is ignored. It does not change the running operation or its result, and it causes no extra `done`.
- R8: `busy` goes high on the edge that accepts `start` and falls on the same edge that raises `done`.
- R9: While reset is held, and right after it is released, `busy` and `done` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| a_in | input | N | Multiplier operand, consumed digit by digit |
| b_in | input | N | Multiplicand, must be below M |
| m_in | input | N | Odd modulus |
| mp_in | input | K | `-M^(-1) mod 2^K` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | N | Montgomery product in `[0, M)` |

## Verification
The hardest case to reach from the ports is an unreduced accumulator that lands between M and 2M, where the final subtraction must take effect. The same applies when the low sum and carry digits cancel only through a carry into bit K, which the dropped low digit has to pass forward. Operands close to M with a modulus near 2^N reach both situations. That is why the bench drives `A = B = M - 1` with `M = 2^N - 1` and with random large odd moduli, alongside random A and B. A second start pulse injected in the middle of an operation exercises the idle-only acceptance rule.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREQ,
    ST_ITER,
    ST_CONV,
    ST_FIN
  } mm_state_e;
endpackage

// File: rtl/mm_qdigit.sv
// Quotient digit: q = ((s + c + cin + digit*b) mod 2^K) * mp mod 2^K.
module mm_qdigit #(
  parameter int K = 4
) (
  input  logic [K-1:0] s_lo_i,
  input  logic [K-1:0] c_lo_i,
  input  logic         cin_i,
  input  logic [K-1:0] digit_i,
  input  logic [K-1:0] b_lo_i,
  input  logic [K-1:0] mp_i,
  output logic [K-1:0] q_o
);
  logic [2*K-1:0] pp;
  logic [K-1:0]   tsum;
  logic [2*K-1:0] qp;

  always_comb begin
    pp   = digit_i * b_lo_i;
    tsum = s_lo_i + c_lo_i + {{(K-1){1'b0}}, cin_i} + pp[K-1:0];
    qp   = tsum * mp_i;
    q_o  = qp[K-1:0];
  end
endmodule

// File: rtl/mm_csa_step.sv
// One digit iteration: adds digit*B and q*M into the redundant accumulator
// through a chain of 3:2 compressors, then drops the low K bits.
module mm_csa_step #(
  parameter int N = 64,
  parameter int K = 4,
  parameter int W = N + K + 2
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] car_i,
  input  logic         cin_i,
  input  logic [K-1:0] digit_i,
  input  logic [K-1:0] q_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] m_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o,
  output logic [K-1:0] low_sum_o,
  output logic [K-1:0] low_car_o
);
  localparam int NOPS = 2 * K + 1;

  logic [W-1:0] ops  [NOPS];
  logic [W-1:0] s_ch [NOPS+1];
  logic [W-1:0] c_ch [NOPS+1];

  assign ops[0] = {{(W-1){1'b0}}, cin_i};

  for (genvar j = 0; j < K; j++) begin : g_pp
    assign ops[2*j+1] = digit_i[j] ? (W'(b_i) << j) : '0;
    assign ops[2*j+2] = q_i[j]     ? (W'(m_i) << j) : '0;
  end

  assign s_ch[0] = sum_i;
  assign c_ch[0] = car_i;

  for (genvar j = 0; j < NOPS; j++) begin : g_csa
    assign s_ch[j+1] = s_ch[j] ^ c_ch[j] ^ ops[j];
    assign c_ch[j+1] = ((s_ch[j] & c_ch[j]) | (s_ch[j] & ops[j]) |
                        (c_ch[j] & ops[j])) << 1;
  end

  assign low_sum_o = s_ch[NOPS][K-1:0];
  assign low_car_o = c_ch[NOPS][K-1:0];
  assign sum_o     = s_ch[NOPS] >> K;
  assign car_o     = c_ch[NOPS] >> K;
endmodule

// File: rtl/mm_cskip_add.sv
// Carry-skip adder: ripple inside each group, group carry bypasses the
// group when every bit propagates.
module mm_cskip_add #(
  parameter int WIDTH = 70,
  parameter int GRP   = 5
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NB = (WIDTH + GRP - 1) / GRP;
  localparam int PW = NB * GRP;

  logic [PW-1:0] ap;
  logic [PW-1:0] bp;
  logic [PW-1:0] sp;
  logic [NB:0]   bc;

  assign ap    = PW'(a_i);
  assign bp    = PW'(b_i);
  assign bc[0] = cin_i;

  for (genvar g = 0; g < NB; g++) begin : g_blk
    logic [GRP:0]   rc;
    logic [GRP-1:0] pr;
    logic [GRP-1:0] gn;

    assign pr = ap[g*GRP +: GRP] ^ bp[g*GRP +: GRP];
    assign gn = ap[g*GRP +: GRP] & bp[g*GRP +: GRP];

    always_comb begin
      rc[0] = bc[g];
      for (int t = 0; t < GRP; t++) begin
        rc[t+1] = gn[t] | (pr[t] & rc[t]);
      end
    end

    assign sp[g*GRP +: GRP] = pr ^ rc[GRP-1:0];
    assign bc[g+1]          = (&pr) ? bc[g] : rc[GRP];
  end

  assign sum_o  = sp[WIDTH-1:0];
  assign cout_o = bc[NB];
endmodule

// File: rtl/mm_montmul.sv
module mm_montmul
  import mm_pkg::*;
#(
  parameter int N      = 64,
  parameter int K      = 4,
  parameter int SKIP_G = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic [N-1:0] m_in,
  input  logic [K-1:0] mp_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  localparam int D    = N / K;
  localparam int CW   = (D > 1) ? $clog2(D) : 1;
  localparam int W    = N + K + 2;
  localparam int CVW  = W + 1;
  localparam logic [CW-1:0] LAST = CW'(D - 1);

  mm_state_e     state;
  logic [N-1:0]  a_sh;
  logic [N-1:0]  b_r;
  logic [N-1:0]  m_r;
  logic [K-1:0]  mp_r;
  logic [W-1:0]  ss;
  logic [W-1:0]  sc;
  logic          cin_r;
  logic [K-1:0]  q_r;
  logic [CW-1:0] cnt;
  logic [CVW-1:0] conv_r;

  // iteration datapath
  logic [W-1:0] nx_s;
  logic [W-1:0] nx_c;
  logic [K-1:0] lo_s;
  logic [K-1:0] lo_c;
  logic         nx_cin;

  mm_csa_step #(.N(N), .K(K), .W(W)) u_step (
    .sum_i    (ss),
    .car_i    (sc),
    .cin_i    (cin_r),
    .digit_i  (a_sh[K-1:0]),
    .q_i      (q_r),
    .b_i      (b_r),
    .m_i      (m_r),
    .sum_o    (nx_s),
    .car_o    (nx_c),
    .low_sum_o(lo_s),
    .low_car_o(lo_c)
  );

  // the dropped low digit is zero modulo 2^K; a nonzero pair carries one
  assign nx_cin = |(lo_s | lo_c);

  // quotient precompute: current state in PREQ, next state in ITER
  logic [K-1:0] qs_lo;
  logic [K-1:0] qc_lo;
  logic         q_cin;
  logic [K-1:0] q_dig;
  logic [K-1:0] q_nx;

  always_comb begin
    if (state == ST_PREQ) begin
      qs_lo = ss[K-1:0];
      qc_lo = sc[K-1:0];
      q_cin = cin_r;
      q_dig = a_sh[K-1:0];
    end else begin
      qs_lo = nx_s[K-1:0];
      qc_lo = nx_c[K-1:0];
      q_cin = nx_cin;
      q_dig = a_sh[2*K-1:K];
    end
  end

  mm_qdigit #(.K(K)) u_qdig (
    .s_lo_i (qs_lo),
    .c_lo_i (qc_lo),
    .cin_i  (q_cin),
    .digit_i(q_dig),
    .b_lo_i (b_r[K-1:0]),
    .mp_i   (mp_r),
    .q_o    (q_nx)
  );

  // redundant-to-binary conversion
  logic [W-1:0] conv_sum;
  logic         conv_co;

  mm_cskip_add #(.WIDTH(W), .GRP(SKIP_G)) u_conv (
    .a_i   (ss),
    .b_i   (sc),
    .cin_i (cin_r),
    .sum_o (conv_sum),
    .cout_o(conv_co)
  );

  // final conditional subtraction
  logic         ge_m;
  logic [N-1:0] red;

  always_comb begin
    ge_m = conv_r >= CVW'(m_r);
    red  = ge_m ? N'(conv_r - CVW'(m_r)) : conv_r[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      a_sh   <= '0;
      b_r    <= '0;
      m_r    <= '0;
      mp_r   <= '0;
      ss     <= '0;
      sc     <= '0;
      cin_r  <= 1'b0;
      q_r    <= '0;
      cnt    <= '0;
      conv_r <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            a_sh  <= a_in;
            b_r   <= b_in;
            m_r   <= m_in;
            mp_r  <= mp_in;
            ss    <= '0;
            sc    <= '0;
            cin_r <= 1'b0;
            cnt   <= '0;
            busy  <= 1'b1;
            state <= ST_PREQ;
          end
        end
        ST_PREQ: begin
          q_r   <= q_nx;
          state <= ST_ITER;
        end
        ST_ITER: begin
          ss    <= nx_s;
          sc    <= nx_c;
          cin_r <= nx_cin;
          q_r   <= q_nx;
          a_sh  <= a_sh >> K;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_CONV;
        end
        ST_CONV: begin
          conv_r <= {conv_co, conv_sum};
          state  <= ST_FIN;
        end
        ST_FIN: begin
          result <= red;
          done   <= 1'b1;
          busy   <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [K-1:0] lo_tot;
  assign lo_tot = lo_s + lo_c;

  // R1: the registered quotient must clear the low digit of every step
  a_r1_digit_cleared: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ITER) |-> (lo_tot == '0));

  // R2: the converted accumulator stays below 2M before the subtraction
  a_r2_pre_sub_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |-> (conv_r < (CVW'(m_r) << 1)));

  a_r2_result_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < m_r));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  a_r8_busy_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && $past(state == ST_IDLE)));

  a_r8_busy_exit: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/mm_montmul_tb.sv
`timescale 1ns/1ps
module mm_montmul_tb;
  localparam int N = 64;
  localparam int K = 4;
  localparam int D = N / K;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] a_in = '0;
  logic [N-1:0] b_in = '0;
  logic [N-1:0] m_in = '0;
  logic [K-1:0] mp_in = '0;
  logic         busy;
  logic         done;
  logic [N-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mm_montmul #(.N(N), .K(K)) u_dut (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .m_in(m_in), .mp_in(mp_in), .busy(busy), .done(done), .result(result)
  );

  // radix-2 software model of A*B*2^-N mod M
  function automatic logic [N-1:0] mref(input logic [N-1:0] a, b, m);
    logic [N+1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) begin
      if (a[i]) s = s + {2'b00, b};
      if (s[0]) s = s + {2'b00, m};
      s = s >> 1;
    end
    if (s >= {2'b00, m}) s = s - {2'b00, m};
    return s[N-1:0];
  endfunction

  function automatic logic [K-1:0] mpcalc(input logic [N-1:0] m);
    logic [2*K-1:0] p;
    for (int x = 0; x < (1 << K); x++) begin
      p = m[K-1:0] * K'(x);
      if (p[K-1:0] == {K{1'b1}}) return K'(x);
    end
    return '0;
  endfunction

  function automatic logic [N-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // launch one operation; lat = rising edges after the accepting edge
  task automatic run_op(input logic [N-1:0] a, b, m,
                        output logic [N-1:0] res, output int lat);
    @(negedge clk);
    a_in = a; b_in = b; m_in = m; mp_in = mpcalc(m);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  task automatic t_reset();
    check("R9 busy", N'(busy), '0);
    check("R9 done", N'(done), '0);
    check("R9 result", result, '0);
  endtask

  task automatic t_timing();
    logic [N-1:0] a, b, m, r;
    int lat;
    m = rnd64() | 64'h8000_0000_0000_0001;
    a = rnd64();
    b = rnd64() % m;
    @(negedge clk);
    a_in = a; b_in = b; m_in = m; mp_in = mpcalc(m);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after accept", N'(busy), 64'd1);
    lat = 0;
    while (!done) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check("R4 latency", N'(lat), N'(D + 3));
    check("R8 busy low with done", N'(busy), '0);
    r = result;
    check("R1 timed op", r, mref(a, b, m));
    @(negedge clk);
    check("R5 done one cycle", N'(done), '0);
  endtask

  task automatic t_random();
    logic [N-1:0] a, b, m, r;
    int lat;
    for (int i = 0; i < 8; i++) begin
      m = rnd64() | 64'd1;
      if (i % 2 == 0) m[N-1] = 1'b1;
      a = rnd64();
      b = rnd64() % m;
      run_op(a, b, m, r, lat);
      check("R1 random", r, mref(a, b, m));
    end
    m = rnd64() | 64'd1;
    b = rnd64() % m;
    run_op({N{1'b1}}, b, m, r, lat);
    check("R1 all-ones A", r, mref({N{1'b1}}, b, m));
  endtask

  task automatic t_zero();
    logic [N-1:0] m, r;
    int lat;
    m = rnd64() | 64'd1;
    run_op('0, rnd64() % m, m, r, lat);
    check("R3 A zero", r, '0);
    run_op(rnd64(), '0, m, r, lat);
    check("R3 B zero", r, '0);
  endtask

  task automatic t_extremes();
    logic [N-1:0] m, r;
    int lat;
    m = {N{1'b1}};
    run_op(m - 1, m - 1, m, r, lat);
    check("R2 max modulus", r, mref(m - 1, m - 1, m));
    for (int i = 0; i < 3; i++) begin
      m = rnd64() | 64'h8000_0000_0000_0001;
      run_op(m - 1, m - 1, m, r, lat);
      check("R2 operands M-1", r, mref(m - 1, m - 1, m));
    end
    run_op(rnd64(), '0, 64'd1, r, lat);
    check("R2 modulus one", r, '0);
  endtask

  task automatic t_hold();
    logic [N-1:0] a, b, m, r;
    int lat;
    m = rnd64() | 64'd1;
    a = rnd64();
    b = rnd64() % m;
    run_op(a, b, m, r, lat);
    a_in = rnd64(); b_in = rnd64(); m_in = rnd64();
    repeat (6) @(negedge clk);
    check("R6 result held", result, r);
  endtask

  task automatic t_busy_ignore();
    logic [N-1:0] a, b, m, m2, exp;
    bit extra;
    m = rnd64() | 64'd1;
    a = rnd64();
    b = rnd64() % m;
    exp = mref(a, b, m);
    @(negedge clk);
    a_in = a; b_in = b; m_in = m; mp_in = mpcalc(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    m2 = rnd64() | 64'd1;
    a_in = rnd64(); b_in = rnd64() % m2; m_in = m2; mp_in = mpcalc(m2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R7 first result kept", result, exp);
    extra = 1'b0;
    repeat (D + 6) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    check("R7 no second done", N'(extra), '0);
    check("R6 result after ignore", result, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_random();
    t_zero();
    t_extremes();
    t_hold();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule